// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Slave

This block is an SPI slave in front of a 512-entry, 8-bit-wide memory built from on-chip registers. To the host it looks like a serial nonvolatile memory whose writes finish as fast as the bus shifts them in. No busy interval exists, so the host never polls for ready. Each chip-select frame carries exactly one command. The first byte is the command byte. For memory access, that byte also holds the ninth address bit. A byte with the lower eight address bits follows, and then any number of data bytes. The address steps by one after each data byte and wraps around the top of the memory.

SCK, MOSI and chip select are synchronised into the system clock domain, and their edges are detected there. MOSI is sampled at SCK rising edges. MISO changes at SCK falling edges. Clock polarity comes out of edge detection, so frames that start with SCK idle low (mode 0) and frames that start with SCK idle high (mode 3) both decode correctly. A write-enable latch guards memory writes and status writes. A status byte reports that latch, six stored bits, and a ready flag that always reads ready.

Top module: `spi_byte_mem`

## Requirements
- R1: After reset, `miso_oe` is 0 and the status byte reads 0x00.
- R2: Command 0x06 sets the write-enable latch, shown as status bit 1. Command 0x04 clears it. Both take effect when their command byte completes.
- R3: Command byte 0000_A010 writes data bytes, and command byte 0000_A011 reads them. In both, bit 3 (A) is address bit 8, and the next byte is address bits 7..0. Read data comes back MSB first.
- R4: A memory write or status write made while the write-enable latch is clear leaves memory and status unchanged.
- R5: When a frame that held a write command or a status-write command ends with chip select going high, the write-enable latch is cleared.
- R6: In both read and write bursts, the address steps by one per data byte and wraps from 0x1FF to 0x000.
- R7: Only the first byte of a frame is decoded as a command. Any later byte in the same frame never starts another command.
- R8: `miso_oe` is 0 while chip select is high and during the command and address bytes. It is 1 while read data or status data is being shifted out.
- R9: Command 0x05 returns the status byte: bits 7..2 are stored bits, bit 1 is the write-enable latch, and bit 0 is always 0 (ready). It repeats for every further byte of the frame. Command 0x01 with the latch set loads status bits 7..2 from the data byte.
- R10: Frames behave identically whether SCK idles low (mode 0) or high (mode 3) when chip select falls.
- R11: A command byte that matches no command has no effect on memory, status or `miso_oe` for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
The bench uses the default of two synchroniser stages and drives SCK with a half period of eight system clocks. This leaves MISO settled well before each rising edge at which the host samples it. The memory uses its full 512 entries, so a burst that starts at 0x1FE reaches the top of memory and carries on through the wrap to 0x000 and 0x001. That exercises address bit 8 in both directions. Mode 3 frames reuse the write and read sequences, which shows that the extra SCK fall before the first bit is harmless.

// File: rtl/spi_byte_mem.sv
module spi_byte_mem #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {P_OPC, P_ADR, P_DATA, P_IDLE} phase_t;
  typedef enum logic [2:0] {C_NONE, C_READ, C_WRITE, C_RDSR, C_WRSR, C_OTHER} cmd_t;

  logic [SYNC_STAGES-1:0] cs_p, sck_p, mosi_p;
  logic                   sck_d;
  logic [2:0]             bitcnt;
  logic [6:0]             sh;
  phase_t                 ph_q;
  cmd_t                   cmd_q;
  logic [ADDR_W-1:0]      addr_q;
  logic                   wel_q;
  logic [5:0]             srb_q;
  logic [7:0]             out_byte;
  logic                   miso_r, oe_r;
  logic [7:0]             mem [DEPTH];

  wire cs_s   = cs_p[SYNC_STAGES-1];
  wire sck_s  = sck_p[SYNC_STAGES-1];
  wire mosi_s = mosi_p[SYNC_STAGES-1];
  wire rise   = !cs_s && sck_s && !sck_d;
  wire fall   = !cs_s && !sck_s && sck_d;
  wire byte_done = rise && (bitcnt == 3'd7);
  wire [7:0] byte_in = {sh, mosi_s};
  wire [7:0] status  = {srb_q, wel_q, 1'b0};
  wire [ADDR_W-1:0] next_addr = addr_q + 1'b1;
  wire out_phase = (ph_q == P_DATA) && (cmd_q == C_READ || cmd_q == C_RDSR);
  wire data_byte = byte_done && (ph_q == P_DATA);
  wire wr_en = data_byte && (cmd_q == C_WRITE) && wel_q;

  assign miso    = miso_r;
  assign miso_oe = oe_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p     <= '1;
      sck_p    <= '0;
      mosi_p   <= '0;
      sck_d    <= 1'b0;
      bitcnt   <= '0;
      sh       <= '0;
      ph_q     <= P_OPC;
      cmd_q    <= C_NONE;
      addr_q   <= '0;
      wel_q    <= 1'b0;
      srb_q    <= '0;
      out_byte <= '0;
      miso_r   <= 1'b0;
      oe_r     <= 1'b0;
    end else begin
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      sck_p  <= {sck_p[SYNC_STAGES-2:0], sck};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
      sck_d  <= sck_s;
      if (cs_s) begin
        bitcnt <= '0;
        ph_q   <= P_OPC;
        oe_r   <= 1'b0;
        cmd_q  <= C_NONE;
        if (cmd_q == C_WRITE || cmd_q == C_WRSR) wel_q <= 1'b0;
      end else begin
        if (rise) begin
          sh     <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          unique case (ph_q)
            P_OPC: begin
              if (byte_in[7:4] == 4'h0 && byte_in[2:0] == 3'b011) begin
                cmd_q <= C_READ;  addr_q[8] <= byte_in[3]; ph_q <= P_ADR;
              end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == 3'b010) begin
                cmd_q <= C_WRITE; addr_q[8] <= byte_in[3]; ph_q <= P_ADR;
              end else begin
                case (byte_in)
                  8'h06: begin wel_q <= 1'b1; cmd_q <= C_OTHER; ph_q <= P_IDLE; end
                  8'h04: begin wel_q <= 1'b0; cmd_q <= C_OTHER; ph_q <= P_IDLE; end
                  8'h05: begin cmd_q <= C_RDSR; out_byte <= status; ph_q <= P_DATA; end
                  8'h01: begin cmd_q <= C_WRSR; ph_q <= P_DATA; end
                  default: begin cmd_q <= C_OTHER; ph_q <= P_IDLE; end
                endcase
              end
            end
            P_ADR: begin
              addr_q[7:0] <= byte_in;
              out_byte    <= mem[{addr_q[8], byte_in}];
              ph_q        <= P_DATA;
            end
            P_DATA: begin
              case (cmd_q)
                C_READ:  begin out_byte <= mem[next_addr]; addr_q <= next_addr; end
                C_WRITE: addr_q <= next_addr;
                C_RDSR:  out_byte <= status;
                C_WRSR:  if (wel_q) srb_q <= byte_in[7:2];
                default: ;
              endcase
            end
            default: ;
          endcase
        end
        if (fall && out_phase) begin
          miso_r <= out_byte[3'd7 - bitcnt];
          oe_r   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr_q] <= byte_in;
  end

  // R4
  no_write_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_q |=> (mem[$past(addr_q)] == $past(mem[addr_q])));

  // R5
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && (cmd_q == C_WRITE || cmd_q == C_WRSR)) |=> !wel_q);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_byte && !cs_s && (cmd_q == C_READ || cmd_q == C_WRITE))
      |=> (addr_q == $past(addr_q) + 1'b1));

  // R7
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && ph_q != P_OPC) |=> $stable(cmd_q));

  // R8
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso_oe);

  // R8
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_phase |-> !miso_oe);
endmodule

// File: tb/tb_spi_byte_mem.sv
module tb_spi_byte_mem;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic mode3 = 1'b0;
  logic oe_and, oe_or;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_byte_mem dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
                    .mosi(mosi), .miso(miso), .miso_oe(miso_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cs_lo();
    sck = mode3;
    repeat (H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_hi();
    if (!mode3) sck = 1'b0;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    oe_and = 1'b1; oe_or = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = miso;
      oe_and &= miso_oe; oe_or |= miso_oe;
      sck = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xfer(op, r); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    cs_lo(); xfer(8'h05, r); xfer(8'h00, s); cs_hi();
  endtask

  task automatic wr_frame(input logic [7:0] op, input logic [7:0] a,
                          input logic [31:0] d, input int n);
    logic [7:0] r;
    cs_lo(); xfer(op, r); xfer(a, r);
    for (int k = 0; k < n; k++) xfer(d[31-8*k -: 8], r);
    cs_hi();
  endtask

  task automatic rd_frame(input logic [7:0] op, input logic [7:0] a,
                          input int n, output logic [31:0] d);
    logic [7:0] r;
    d = '0;
    cs_lo(); xfer(op, r); xfer(a, r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      d[31-8*k -: 8] = r;
    end
    cs_hi();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 oe after reset", miso_oe, 0);
    rdsr(s);
    check("R1 status after reset", s, 8'h00);
    check("R9 ready bit", s[0], 0);
  endtask

  task automatic t_wel();
    logic [7:0] s;
    cmd1(8'h06); rdsr(s);
    check("R2 latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s);
    check("R2 latch clear", s, 8'h00);
  endtask

  task automatic t_write_read();
    logic [31:0] d; logic [7:0] s;
    cmd1(8'h06); wr_frame(8'h02, 8'h10, 32'hA500_0000, 1);
    rdsr(s);
    check("R5 latch cleared after write", s, 8'h00);
    cmd1(8'h06); wr_frame(8'h0A, 8'h10, 32'h3C00_0000, 1);
    rd_frame(8'h03, 8'h10, 1, d);
    check("R3 read low half", d[31:24], 8'hA5);
    rd_frame(8'h0B, 8'h10, 1, d);
    check("R3 read high half via A8", d[31:24], 8'h3C);
  endtask

  task automatic t_protect();
    logic [31:0] d; logic [7:0] s;
    wr_frame(8'h02, 8'h10, 32'hFF00_0000, 1);
    rd_frame(8'h03, 8'h10, 1, d);
    check("R4 locked write ignored", d[31:24], 8'hA5);
    wr_frame(8'h01, 8'h00, 32'h0, 0);
    rdsr(s);
    check("R4 status unchanged", s, 8'h00);
  endtask

  task automatic t_burst();
    logic [31:0] d;
    cmd1(8'h06); wr_frame(8'h0A, 8'hFE, 32'h1122_3344, 4);
    rd_frame(8'h0B, 8'hFE, 4, d);
    check("R6 read burst across wrap", d, 32'h1122_3344);
    rd_frame(8'h03, 8'h00, 2, d);
    check("R6 write wrapped to 0x000", d[31:16], 16'h3344);
  endtask

  task automatic t_one_cmd();
    logic [7:0] r, s, s2;
    cs_lo(); xfer(8'h06, r); xfer(8'h04, r); xfer(8'h04, r); cs_hi();
    rdsr(s);
    check("R7 later bytes ignored (set)", s, 8'h02);
    cs_lo(); xfer(8'h04, r); xfer(8'h06, r); cs_hi();
    rdsr(s);
    check("R7 later bytes ignored (clear)", s, 8'h00);
    cmd1(8'h06);
    cs_lo(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, s2); cs_hi();
    check("R9 repeated status byte", {s, s2}, 16'h0202);
    cmd1(8'h04);
  endtask

  task automatic t_oe();
    logic [7:0] r;
    cs_lo();
    xfer(8'h03, r); check("R8 oe low in command", oe_or, 0);
    xfer(8'h10, r); check("R8 oe low in address", oe_or, 0);
    xfer(8'h00, r); check("R8 oe high in data", oe_and, 1);
    check("R3 data during oe test", r, 8'hA5);
    cs_hi();
    check("R8 oe low after deselect", miso_oe, 0);
  endtask

  task automatic t_wrsr();
    logic [7:0] s;
    cmd1(8'h06); wr_frame(8'h01, 8'hFF, 32'h0, 0);
    rdsr(s);
    check("R9 status write stores bits 7..2", s, 8'hFC);
    wr_frame(8'h01, 8'h00, 32'h0, 0);
    rdsr(s);
    check("R4 locked status write", s, 8'hFC);
    cmd1(8'h06); wr_frame(8'h01, 8'h00, 32'h0, 0);
    rdsr(s);
    check("R5 status write clears latch", s, 8'h00);
  endtask

  task automatic t_mode3();
    logic [31:0] d; logic [7:0] s;
    mode3 = 1'b1;
    cmd1(8'h06); rdsr(s);
    check("R10 mode 3 latch set", s, 8'h02);
    wr_frame(8'h0A, 8'h55, 32'h5AC3_0000, 2);
    rd_frame(8'h0B, 8'h55, 2, d);
    check("R10 mode 3 burst", d[31:16], 16'h5AC3);
    mode3 = 1'b0;
    rd_frame(8'h0B, 8'h56, 1, d);
    check("R10 mode 0 after mode 3", d[31:24], 8'hC3);
  endtask

  task automatic t_unknown();
    logic [7:0] r, s; logic [31:0] d;
    cmd1(8'h06);
    cs_lo(); xfer(8'hFF, r); xfer(8'h02, r); xfer(8'h10, r);
    check("R11 no output on unknown", oe_or, 0);
    xfer(8'h77, r); cs_hi();
    rdsr(s);
    check("R11 status unchanged", s, 8'h02);
    rd_frame(8'h03, 8'h10, 1, d);
    check("R11 memory unchanged", d[31:24], 8'hA5);
    cmd1(8'h04);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_wel();
    t_write_read();
    t_protect();
    t_burst();
    t_one_cmd();
    t_oe();
    t_wrsr();
    t_mode3();
    t_unknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule